// File: doc/BRIEF.md
# Distance-Keyed Zero-Correlation Chip Spreader

This block sits on the transmit side of a screen-to-camera optical link. It takes a serial stream of data bits and replaces each bit with a short run of binary chips from a zero-correlation-duration code. The receiver can then despread the frames without a shared timing reference. The block stores four code sets, one for each receiver distance class: about 1 m, 2 m, 3 m, and 4 m or more, all at a 30 Hz frame rate. Each set holds a pair of 8-chip codes, called A and B. With 8 chips per bit, the net data rate falls by the spreading factor.

A 2-bit selector chooses the distance set. A one-cycle frame strobe marks the start of each video frame. Successive frames use the two codes of the pair in turn, beginning with A after reset. The output carries a tag that names the code in use. A receiver can then discard frames it has captured twice, or frames that mix both codes. Software can rewrite any code, and the chip count of any set, while the block runs.

A state machine with two states does the spreading. IDLE holds `in_ready` high. The transition IDLE→SEND happens when a bit is accepted; the code, length and tag are captured at that moment. The transition SEND→SEND happens on each consumed chip that is not the last. The transition SEND→IDLE happens when the last chip is consumed.

Top module: `zcd_spreader`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The active set is set index 0 and the phase is code A, so `out_code_b` reads 0 for the first bit.
- R2: Chips are encoded as 1 for +1 and 0 for -1, and they leave most significant chip first. A data bit of 1 sends the selected code unchanged.
- R3: A data bit of 0 sends the bitwise inverse of the selected code.
- R4: Each `frame_start` pulse swaps the phase between code A and code B. `out_code_b` is 1 while a bit is spread with code B.
- R5: A change on `set_sel` has no effect until the next `frame_start` pulse, which loads it.
- R6: While `out_ready` is 1, one chip is consumed per clock. While `out_ready` is 0, `out_valid`, `out_chip` and `out_code_b` hold their values.
- R7: `in_ready` is 0 while any chip of the current bit is still pending. A new bit is accepted only in IDLE.
- R8: The reset contents, with MSB first and hex 1 meaning +1, are:
  - set 0: A=E2, B=B7
  - set 1: A=B8, B=ED
  - set 2: A=1D, B=48
  - set 3: A=47, B=12
  
  Every set's length resets to 8.
- R9: A write with `cfg_we`=1 and `cfg_field` set to 0 (code A) or 1 (code B) replaces that code of set `cfg_set` with `cfg_data`. A bit accepted before the write keeps its captured chips.
- R10: A write with `cfg_field`=2 sets the chip count L of `cfg_set` from `cfg_data[3:0]`. The spreader then sends only the top L chips of the code. Values of 0 or above 8 are ignored. `cfg_field`=3 writes nothing.
- R11: A `frame_start` pulse that arrives while a bit is being sent leaves that bit's chips and tag unchanged. The pulse applies from the next accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_sel | input | 2 | Distance set wanted from the next frame |
| frame_start | input | 1 | One-cycle video frame start strobe |
| in_valid | input | 1 | Data bit offered |
| in_bit | input | 1 | Data bit value |
| in_ready | output | 1 | Block can take a bit |
| out_valid | output | 1 | Chip present |
| out_chip | output | 1 | Chip value (1 means +1) |
| out_code_b | output | 1 | Chip belongs to code B of the pair |
| out_ready | input | 1 | Sink takes the chip |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_set | input | 2 | Set written |
| cfg_field | input | 2 | 0 code A, 1 code B, 2 length, 3 none |
| cfg_data | input | 8 | Code value or length |

## Verification
Suppose the phase register is wrong. The tag and the chip pattern of the first bit after a frame pulse then show the wrong code, so the error is visible within one bit time of that pulse. Suppose instead that the chip counter or shift register is corrupt. The bit's chip sequence is then altered or truncated, and `in_ready` returns too early or too late. The error appears within at most eight chip cycles. A stale set latch shows up only after a frame pulse, as a code from the wrong distance class. The tests therefore pulse frames with the selector changed both before and during a bit.

// File: rtl/zcd_pkg.sv
package zcd_pkg;

    localparam int CODE_CHIPS = 8;
    localparam int CODE_SETS  = 4;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } spread_state_t;

    typedef enum logic [1:0] {
        F_CODE_A = 2'd0,
        F_CODE_B = 2'd1,
        F_LENGTH = 2'd2,
        F_NONE   = 2'd3
    } cfg_field_t;

    // Reset contents of the code bank, chip +1 stored as 1, MSB sent first.
    function automatic logic [CODE_CHIPS-1:0] reset_code(input int set_idx, input logic pick_b);
        logic [CODE_CHIPS-1:0] v;
        case ({set_idx[1:0], pick_b})
            3'b000:  v = 8'hE2;
            3'b001:  v = 8'hB7;
            3'b010:  v = 8'hB8;
            3'b011:  v = 8'hED;
            3'b100:  v = 8'h1D;
            3'b101:  v = 8'h48;
            3'b110:  v = 8'h47;
            default: v = 8'h12;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/zcd_code_bank.sv
module zcd_code_bank #(
    parameter int CHIPS = zcd_pkg::CODE_CHIPS,
    parameter int NSETS = zcd_pkg::CODE_SETS,
    parameter int SEL_W = $clog2(NSETS),
    parameter int LEN_W = $clog2(CHIPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_set,
    input  logic [1:0]       cfg_field,
    input  logic [CHIPS-1:0] cfg_data,
    input  logic [SEL_W-1:0] rd_set,
    output logic [CHIPS-1:0] rd_code_a,
    output logic [CHIPS-1:0] rd_code_b,
    output logic [LEN_W-1:0] rd_len
);
    import zcd_pkg::*;

    logic [CHIPS-1:0] all_a   [NSETS];
    logic [CHIPS-1:0] all_b   [NSETS];
    logic [LEN_W-1:0] all_len [NSETS];

    logic [LEN_W-1:0] len_req;
    logic             len_ok;

    assign len_req = cfg_data[LEN_W-1:0];
    assign len_ok  = (len_req != '0) && (len_req <= LEN_W'(CHIPS));

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        logic [CHIPS-1:0] a_q;
        logic [CHIPS-1:0] b_q;
        logic [LEN_W-1:0] len_q;
        logic             hit;

        assign hit = cfg_we && (cfg_set == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q   <= CHIPS'(reset_code(g, 1'b0));
                b_q   <= CHIPS'(reset_code(g, 1'b1));
                len_q <= LEN_W'(CHIPS);
            end else if (hit) begin
                unique case (cfg_field_t'(cfg_field))
                    F_CODE_A: a_q <= cfg_data;
                    F_CODE_B: b_q <= cfg_data;
                    F_LENGTH: if (len_ok) len_q <= len_req;
                    F_NONE:   ;
                endcase
            end
        end

        assign all_a[g]   = a_q;
        assign all_b[g]   = b_q;
        assign all_len[g] = len_q;
    end

    assign rd_code_a = all_a[rd_set];
    assign rd_code_b = all_b[rd_set];
    assign rd_len    = all_len[rd_set];

endmodule

// File: rtl/zcd_frame_ctrl.sv
module zcd_frame_ctrl #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [SEL_W-1:0] set_sel,
    output logic [SEL_W-1:0] active_set,
    output logic             phase_b
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_set <= '0;
            phase_b    <= 1'b0;
        end else if (frame_start) begin
            active_set <= set_sel;
            phase_b    <= ~phase_b;
        end
    end

endmodule

// File: rtl/zcd_chip_fsm.sv
module zcd_chip_fsm #(
    parameter int CHIPS = 8,
    parameter int LEN_W = $clog2(CHIPS + 1),
    parameter int CNT_W = $clog2(CHIPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic [CHIPS-1:0] code,
    input  logic [LEN_W-1:0] len,
    input  logic             phase_b,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_chip,
    output logic             out_code_b
);
    import zcd_pkg::*;

    spread_state_t    state_q, state_d;
    logic [CHIPS-1:0] word_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             tag_q;
    logic             accept;
    logic             last_chip;

    assign accept    = (state_q == S_IDLE) && in_valid;
    assign last_chip = (LEN_W'(cnt_q) == (len_q - LEN_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid) state_d = S_SEND;
            S_SEND: if (out_ready && last_chip) state_d = S_IDLE;
        endcase
    end

    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        unique case (state_q)
            S_IDLE: in_ready  = 1'b1;
            S_SEND: out_valid = 1'b1;
        endcase
        out_chip   = word_q[CHIPS-1];
        out_code_b = tag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            len_q  <= LEN_W'(CHIPS);
            tag_q  <= 1'b0;
        end else if (accept) begin
            word_q <= in_bit ? code : ~code;
            cnt_q  <= '0;
            len_q  <= len;
            tag_q  <= phase_b;
        end else if (state_q == S_SEND && out_ready) begin
            word_q <= word_q << 1;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/zcd_spreader.sv
module zcd_spreader #(
    parameter int CHIPS = zcd_pkg::CODE_CHIPS,
    parameter int NSETS = zcd_pkg::CODE_SETS,
    parameter int SEL_W = $clog2(NSETS),
    parameter int LEN_W = $clog2(CHIPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] set_sel,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_chip,
    output logic             out_code_b,
    input  logic             out_ready,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_set,
    input  logic [1:0]       cfg_field,
    input  logic [CHIPS-1:0] cfg_data
);
    logic [SEL_W-1:0] active_set;
    logic             phase_b;
    logic [CHIPS-1:0] code_a, code_b, code_sel;
    logic [LEN_W-1:0] code_len;

    zcd_frame_ctrl #(.SEL_W(SEL_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .set_sel(set_sel), .active_set(active_set), .phase_b(phase_b)
    );

    zcd_code_bank #(.CHIPS(CHIPS), .NSETS(NSETS), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_set(cfg_set),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .rd_set(active_set),
        .rd_code_a(code_a), .rd_code_b(code_b), .rd_len(code_len)
    );

    assign code_sel = phase_b ? code_b : code_a;

    zcd_chip_fsm #(.CHIPS(CHIPS), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .code(code_sel), .len(code_len), .phase_b(phase_b), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid), .out_chip(out_chip),
        .out_code_b(out_code_b)
    );

endmodule

// File: rtl/zcd_spreader_chk.sv
module zcd_spreader_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_chip,
    input logic             out_code_b,
    input logic             phase_b,
    input logic [SEL_W-1:0] active_set
);
    // R1: with no chip pending the block takes input
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R4: every frame pulse swaps the pair phase
    p_phase_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (phase_b != $past(phase_b)));

    // R5: the active set moves only on a frame pulse
    p_set_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active_set));

    // R6: a stalled chip stays put
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chip) && $stable(out_code_b)));

    // R7: no input taken while chips are pending
    p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

endmodule

bind zcd_spreader zcd_spreader_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_chip(out_chip),
    .out_code_b(out_code_b), .phase_b(phase_b), .active_set(active_set)
);

// File: tb/zcd_spreader_bench.sv
module zcd_spreader_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] set_sel = '0;
    logic       frame_start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_ready, out_valid, out_chip, out_code_b;
    logic       out_ready = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_set = '0;
    logic [1:0] cfg_field = '0;
    logic [7:0] cfg_data = '0;

    int checks = 0;
    int fails  = 0;

    // bench model of block state
    logic [7:0] m_a [4];
    logic [7:0] m_b [4];
    int         m_len [4];
    int         m_set = 0;
    logic       m_ph = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zcd_spreader u_zcd_spreader (
        .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .frame_start(frame_start),
        .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
        .out_valid(out_valid), .out_chip(out_chip), .out_code_b(out_code_b),
        .out_ready(out_ready), .cfg_we(cfg_we), .cfg_set(cfg_set),
        .cfg_field(cfg_field), .cfg_data(cfg_data)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_word(input logic b);
        logic [7:0] c;
        c = m_ph ? m_b[m_set] : m_a[m_set];
        if (!b) c = ~c;
        return c >> (8 - m_len[m_set]);
    endfunction

    task automatic pulse_frame(input logic [1:0] s);
        @(negedge clk);
        set_sel = s; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_set = int'(s); m_ph = ~m_ph;
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [1:0] f, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_set = s; cfg_field = f; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Send one bit and collect its chips. action: 0 none, 1 stall, 2 config write, 3 frame pulse.
    task automatic run_bit(input logic b, input int action, input string req,
                           input logic [1:0] a_set, input logic [1:0] a_fld, input logic [7:0] a_dat);
        logic [7:0] got;
        logic [7:0] exp;
        logic       tag_exp;
        logic       tag_ok;
        int         n;
        exp = expect_word(b);
        tag_exp = m_ph;
        got = '0; n = 0; tag_ok = 1'b1;
        @(negedge clk);
        check(in_ready, req, in_ready, 1);
        in_valid = 1'b1; in_bit = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (!out_valid) break;
            if (n == 1 && action == 1) begin
                logic held;
                held = out_chip;
                out_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(posedge clk); @(negedge clk);
                    check(out_valid && out_chip == held && !in_ready, "R6/R7 stall hold",
                          {out_valid, out_chip, in_ready}, {1'b1, held, 1'b0});
                end
                out_ready = 1'b1;
            end
            got = {got[6:0], out_chip};
            if (out_code_b != tag_exp) tag_ok = 1'b0;
            n++;
            if (n == 2 && action == 2) begin
                cfg_we = 1'b1; cfg_set = a_set; cfg_field = a_fld; cfg_data = a_dat;
            end
            if (n == 2 && action == 3) begin
                set_sel = a_set; frame_start = 1'b1;
            end
            if (n < 8) check(!in_ready, "R7 busy", in_ready, 0);
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
            frame_start = 1'b0;
        end
        check(n == m_len[m_set] && got == exp, req, {got, 8'(n)}, {exp, 8'(m_len[m_set])});
        check(tag_ok, {req, " tag"}, tag_ok, 1);
        if (action == 3) begin m_set = int'(a_set); m_ph = ~m_ph; end
    endtask

    task automatic t_reset();
        check(!out_valid && in_ready, "R1 idle after reset", {out_valid, in_ready}, 2'b01);
        run_bit(1'b1, 0, "R1/R2 set0 code A as-is", 0, 0, 0);
    endtask

    task automatic t_polarity();
        run_bit(1'b0, 0, "R3 inverted for zero", 0, 0, 0);
        run_bit(1'b1, 0, "R2 one again", 0, 0, 0);
    endtask

    task automatic t_alternate();
        pulse_frame(2'd0);
        run_bit(1'b1, 0, "R4 code B after pulse", 0, 0, 0);
        pulse_frame(2'd0);
        run_bit(1'b1, 0, "R4 back to code A", 0, 0, 0);
    endtask

    task automatic t_select();
        @(negedge clk); set_sel = 2'd2;
        run_bit(1'b1, 0, "R5 selector ignored without pulse", 0, 0, 0);
        for (int s = 0; s < 4; s++) begin
            pulse_frame(2'(s));
            run_bit(1'b1, 0, "R8 default table", 0, 0, 0);
            pulse_frame(2'(s));
            run_bit(1'b0, 0, "R8 default table pair", 0, 0, 0);
        end
    endtask

    task automatic t_stall();
        run_bit(1'b1, 1, "R6 chips after stall", 0, 0, 0);
    endtask

    task automatic t_config();
        logic [1:0] s;
        s = 2'(m_set);
        run_bit(1'b1, 2, "R9 in-flight bit unchanged", s, 2'd0, 8'h5A);
        m_a[m_set] = 8'h5A;
        cfg_write(s, 2'd1, 8'hC3); m_b[m_set] = 8'hC3;
        cfg_write(s, 2'd3, 8'hFF);
        run_bit(1'b1, 0, "R9 new code used", 0, 0, 0);
        pulse_frame(s);
        run_bit(1'b0, 0, "R9 new other code used", 0, 0, 0);
    endtask

    task automatic t_length();
        logic [1:0] s;
        s = 2'(m_set);
        cfg_write(s, 2'd2, 8'd5); m_len[m_set] = 5;
        run_bit(1'b1, 0, "R10 five chips", 0, 0, 0);
        cfg_write(s, 2'd2, 8'd0);
        cfg_write(s, 2'd2, 8'd9);
        run_bit(1'b0, 0, "R10 bad lengths ignored", 0, 0, 0);
        cfg_write(s, 2'd2, 8'd8); m_len[m_set] = 8;
        run_bit(1'b1, 0, "R10 full length restored", 0, 0, 0);
    endtask

    task automatic t_midstrobe();
        run_bit(1'b1, 3, "R11 bit unchanged by mid pulse", 2'd1, 0, 0);
        run_bit(1'b1, 0, "R11 pulse applies next bit", 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_a[0] = 8'hE2; m_b[0] = 8'hB7; m_a[1] = 8'hB8; m_b[1] = 8'hED;
        m_a[2] = 8'h1D; m_b[2] = 8'h48; m_a[3] = 8'h47; m_b[3] = 8'h12;
        for (int i = 0; i < 4; i++) m_len[i] = 8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_polarity();
        t_alternate();
        t_select();
        t_stall();
        t_config();
        t_length();
        t_midstrobe();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule